// File: doc/BRIEF.md
# SDI Video Scrambler with NRZI Line Coder

This block prepares a 10-bit parallel standard-definition serial digital video word stream for an external serializer. It codes one word per clock. When video coding is selected, each word goes first through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1. The scrambled bits then go through an NRZI coder with the polynomial x + 1, whose output toggles on every 1. Both stages work LSB first. The ten bit-serial steps are unrolled so that a whole word is handled in one clock.

Two mode pins choose the path. Video coding is active only when `video_sel_i` is high and `async_sel_i` is low. In every other combination the word passes through unchanged. When both pins are low, this is a raw bypass. When `async_sel_i` is high, the data has already been line-coded upstream for the asynchronous serial interface. The 9-bit scrambler history and the 1-bit NRZI level carry over from one word to the next. They advance only on valid words in video mode, so a serializer can change modes or insert idle cycles without breaking the coded stream.

Top module: `sdi_scrambler_nrzi`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after its release with no valid input, `valid_o` is 0 and `data_o` is 0. Both the scrambler history and the NRZI level start at zero.
- R2: In video mode (`video_sel_i`=1, `async_sel_i`=0), each bit is handled from bit 0 upward. The scrambled bit is s[n] = d[n] ^ s[n-4] ^ s[n-9], and the output bit is q[n] = s[n] ^ q[n-1]. The bit history runs continuously across word boundaries.
- R3: `valid_o` equals `valid_i` delayed by exactly one clock, and a coded word appears on `data_o` one clock after it is accepted.
- R4: With `video_sel_i`=0 and `async_sel_i`=0, `data_o` equals the `data_i` accepted one clock earlier, bit for bit.
- R5: With `async_sel_i`=1, `data_o` equals the `data_i` accepted one clock earlier, whatever the value of `video_sel_i`.
- R6: A cycle with `valid_i`=0 changes neither the coder state nor `data_o`. The coded stream after an idle gap is identical to the stream with no gap.
- R7: Apply NRZI decoding (s[n] = q[n] ^ q[n-1]) and then the inverse scrambler (d[n] = s[n] ^ s[n-4] ^ s[n-9]) to the video output. This recovers the input words once 9 bits have settled.
- R8: Words accepted in bypass or asynchronous mode leave the coder state untouched. Coding resumes from the state left by the last video word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 10 | Parallel input word, bit 0 first in serial order |
| valid_i | input | 1 | Input word strobe |
| video_sel_i | input | 1 | Video coding select (effective only with async_sel_i low) |
| async_sel_i | input | 1 | Asynchronous-interface pass-through select |
| data_o | output | 10 | Coded or passed-through word |
| valid_o | output | 1 | Output word strobe |

## Verification
Every result of this block is due one clock after the word that produced it: the coded word, the passed-through word and the valid strobe all come from the same output register stage. The bench drives each word on a falling edge and compares `data_o` and `valid_o` on the next falling edge, half a period after the rising edge that loads them. Its model keeps its own bit history and changes that history only for valid video words. A gap or mode change therefore shows up as a mismatch on the first video word that follows it.

// File: rtl/sdi_coder_pkg.sv
package sdi_coder_pkg;
  typedef enum logic [1:0] {
    MODE_RAW   = 2'd0,
    MODE_VIDEO = 2'd1,
    MODE_ASYNC = 2'd2
  } coder_mode_e;
endpackage

// File: rtl/sdi_mode_decode.sv
module sdi_mode_decode
  import sdi_coder_pkg::*;
(
  input  logic        video_sel_i,
  input  logic        async_sel_i,
  output coder_mode_e mode_o
);
  always_comb begin
    if (async_sel_i)      mode_o = MODE_ASYNC;
    else if (video_sel_i) mode_o = MODE_VIDEO;
    else                  mode_o = MODE_RAW;
  end
endmodule

// File: rtl/sdi_scrambler.sv
module sdi_scrambler #(
  parameter int DATA_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int LenIdx = SCR_LEN - 1;
  localparam int TapIdx = SCR_TAP - 1;

  // hist_q[0] is the most recent scrambled bit
  logic [SCR_LEN-1:0] hist_q, hist_d;

  always_comb begin
    logic [SCR_LEN-1:0] h;
    logic               b;
    h = hist_q;
    for (int i = 0; i < DATA_W; i++) begin
      b         = data_i[i] ^ h[TapIdx] ^ h[LenIdx];
      data_o[i] = b;
      h         = {h[SCR_LEN-2:0], b};
    end
    hist_d = h;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (adv_i) hist_q <= hist_d;
  end

  // R6 / R8: history only moves on accepted video words
  a_r6_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(hist_q));
endmodule

// File: rtl/sdi_nrzi.sv
module sdi_nrzi #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic lvl_q;

  always_comb begin
    logic l;
    l = lvl_q;
    for (int i = 0; i < DATA_W; i++) begin
      l         = l ^ data_i[i];
      data_o[i] = l;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= 1'b0;
    else if (adv_i) lvl_q <= data_o[DATA_W-1];
  end

  // R8: line level frozen outside accepted video words
  a_r8_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(lvl_q));
endmodule

// File: rtl/sdi_scrambler_nrzi.sv
module sdi_scrambler_nrzi
  import sdi_coder_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              video_sel_i,
  input  logic              async_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  coder_mode_e       mode;
  logic              adv;
  logic [DATA_W-1:0] scr_word, line_word;

  sdi_mode_decode u_mode (
    .video_sel_i (video_sel_i),
    .async_sel_i (async_sel_i),
    .mode_o      (mode)
  );

  assign adv = valid_i && (mode == MODE_VIDEO);

  sdi_scrambler #(
    .DATA_W  (DATA_W),
    .SCR_LEN (SCR_LEN),
    .SCR_TAP (SCR_TAP)
  ) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .data_i (data_i),
    .data_o (scr_word)
  );

  sdi_nrzi #(
    .DATA_W (DATA_W)
  ) u_nrzi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .data_i (scr_word),
    .data_o (line_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= (mode == MODE_VIDEO) ? line_word : data_i;
    end
  end

  a_r3_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r3_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r4_raw_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !video_sel_i && !async_sel_i) |=> data_o == $past(data_i));
  a_r5_async_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && async_sel_i) |=> data_o == $past(data_i));
  a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: tb/sdi_scrambler_nrzi_bench.sv
`timescale 1ns/1ps
module sdi_scrambler_nrzi_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       video_sel_i = 1'b0;
  logic       async_sel_i = 1'b0;
  logic [9:0] data_o;
  logic       valid_o;

  int total = 0;
  int bad = 0;

  logic [8:0] m_hist;
  logic       m_lvl;
  logic [9:0] exp_data;
  logic [8:0] d_hist;
  logic       d_prev;

  always #2 clk_i = ~clk_i;

  sdi_scrambler_nrzi u_sdi_scrambler_nrzi (
    .clk_i, .rst_ni, .data_i, .valid_i, .video_sel_i, .async_sel_i, .data_o, .valid_o
  );

  task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; data_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_hist = '0; m_lvl = 1'b0; exp_data = '0;
    d_hist = '0; d_prev = 1'b0;
  endtask

  // drive one word at a falling edge, check the registered result one clock later
  task automatic step(input logic [9:0] d, input logic v, input logic vs, input logic as_, input string tag);
    logic [9:0] q;
    logic b;
    data_i = d; valid_i = v; video_sel_i = vs; async_sel_i = as_;
    if (v) begin
      if (vs && !as_) begin
        for (int i = 0; i < 10; i++) begin
          b = d[i] ^ m_hist[3] ^ m_hist[8];
          m_hist = {m_hist[7:0], b};
          m_lvl = m_lvl ^ b;
          q[i] = m_lvl;
        end
        exp_data = q;
      end else exp_data = d;
    end
    @(negedge clk_i);
    chk(valid_o == v, {tag, " valid (R3)"}, {9'd0, valid_o}, {9'd0, v});
    chk(data_o == exp_data, tag, data_o, exp_data);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(valid_o == 1'b0 && data_o == '0, "R1 in reset", data_o, '0);
    do_reset();
    step('0, 1'b0, 1'b1, 1'b0, "R1 after release");
  endtask

  task automatic t_video();
    do_reset();
    step(10'h000, 1'b1, 1'b1, 1'b0, "R2 zero word");
    step(10'h3FF, 1'b1, 1'b1, 1'b0, "R2 ones word");
    step(10'h001, 1'b1, 1'b1, 1'b0, "R2 single bit");
    for (int k = 0; k < 24; k++)
      step(10'((k * 151 + 37) ^ (k << 5)), 1'b1, 1'b1, 1'b0, "R2 stream");
  endtask

  task automatic t_gap();
    step(10'h2A5, 1'b1, 1'b1, 1'b0, "R6 before gap");
    step(10'h155, 1'b0, 1'b1, 1'b0, "R6 idle word");
    step(10'h0F0, 1'b0, 1'b0, 1'b1, "R6 idle other mode");
    step(10'h31C, 1'b1, 1'b1, 1'b0, "R6 after gap");
    step(10'h0C3, 1'b1, 1'b1, 1'b0, "R6 after gap 2");
  endtask

  task automatic t_raw();
    step(10'h2D7, 1'b1, 1'b0, 1'b0, "R4 raw word");
    step(10'h3FF, 1'b1, 1'b0, 1'b0, "R4 raw ones");
    step(10'h111, 1'b1, 1'b1, 1'b0, "R8 resume after raw");
  endtask

  task automatic t_async();
    step(10'h17C, 1'b1, 1'b0, 1'b1, "R5 async sel only");
    step(10'h283, 1'b1, 1'b1, 1'b1, "R5 async with video sel");
    step(10'h05A, 1'b1, 1'b1, 1'b0, "R8 resume after async");
  endtask

  task automatic t_descramble();
    logic [9:0] w, rec;
    logic s, dd;
    do_reset();
    for (int k = 0; k < 16; k++) begin
      w = 10'((k * 613 + 91) ^ (k << 3));
      step(w, 1'b1, 1'b1, 1'b0, "R7 encode");
      for (int i = 0; i < 10; i++) begin
        s = data_o[i] ^ d_prev;
        d_prev = data_o[i];
        dd = s ^ d_hist[3] ^ d_hist[8];
        d_hist = {d_hist[7:0], s};
        rec[i] = dd;
      end
      if (k > 0) chk(rec == w, "R7 recovered word", rec, w);
    end
  endtask

  initial begin
    repeat (1) @(negedge clk_i);
    t_reset();
    t_video();
    t_gap();
    t_raw();
    t_async();
    t_descramble();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule